// File: doc/BRIEF.md
# Cross-Domain Timer Capture Unit

This block keeps a free-running up-counter in a timer clock domain and lets software in a separate bus clock domain read it safely. Software asks for a snapshot by writing a request bit. The request crosses into the timer domain on a toggle, the running count is latched there, and an acknowledge toggle carries completion back. The bus side then loads the latched value into a capture register and raises a sticky valid flag. Software polls that flag and needs no guessed delay between the request and the read.

The timer clock is chosen between a fast input clock and a slow input clock, nominally 32768 Hz. The choice can be changed only while the counter is stopped. A raw view of the live count is also readable from the bus. That path is not synchronized and can return a value torn by a bit transition. Software accepts it only when two back-to-back reads agree.

Top module: `tcap_top`

## Requirements
- R1: After reset, all four registers read zero. The register map is: address 0 control, address 1 capture value, address 2 status, address 3 live count.
- R2: Control bit 0 enables the counter. While enabled, the counter adds one on every selected timer clock. While disabled, it holds its value.
- R3: The counter is CNT_W bits wide and goes from all-ones to zero.
- R4: Writing control with bit 2 set, while no capture is pending, clears the valid flag (status bit 0) and sets the pending flag (status bit 1) from the next bus cycle. When the capture completes, valid is set and pending is cleared.
- R5: A request written while a capture is pending is ignored. No second capture follows.
- R6: The capture value register keeps its contents until the next completed capture, including while a new request is pending.
- R7: The captured value lies between live counts read before the request and after completion. With the counter stopped, it equals the live count.
- R8: With the fast clock selected, the snapshot is taken on the third timer clock after the request. Valid appears within 20 bus cycles for a fast clock of one third of the bus rate.
- R9: Control bit 1 selects the slow clock when 1 and the fast clock when 0. The count rate and the capture latency follow the selected clock.
- R10: A write to control bit 1 takes effect only if the counter was disabled before that write. Otherwise the select keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| fast_clk | input | 1 | Fast timer clock source |
| slow_clk | input | 1 | Slow timer clock source |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized separately in each domain |
| reg_wr | input | 1 | Write strobe, sampled on bus_clk |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Captures are taken in three situations:
- With the counter running on the fast clock, which shows that the snapshot falls inside the window of surrounding live reads and that latency stays short.
- With the counter stopped, which shows an exact match with the live count.
- With the counter running on the slow clock, where the much longer latency and the lower count rate show that the clock select really reaches the counter.

Back-to-back requests and reads of the capture register while a request is pending show the difference between a request that was ignored and one that was honoured. A narrow-counter instance wraps several times so that the rollover can be seen from the bus.

// File: rtl/tcap_pkg.sv
`timescale 1ns/1ps
package tcap_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CAPT = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_LIVE = 2'd3
    } tcap_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SEL_BIT  = 1;
    localparam int CTRL_REQ_BIT  = 2;
    localparam int STAT_VLD_BIT  = 0;
    localparam int STAT_PEND_BIT = 1;
    localparam int BUS_W         = 32;
endpackage

// File: rtl/tcap_rst_sync.sv
`timescale 1ns/1ps
module tcap_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_n_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_sync_bit.sv
`timescale 1ns/1ps
module tcap_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_tmr_core.sv
`timescale 1ns/1ps
module tcap_tmr_core #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             tmr_clk,
    input  logic             tmr_rst_n,
    input  logic             en_async_i,
    input  logic             req_tgl_async_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] snap_o,
    output logic             ack_tgl_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             req_prev;
        logic             ack_tgl;
    } tmr_st_t;

    tmr_st_t state_d, state_q;
    logic    en_s, req_s, req_edge;

    tcap_sync_bit #(.STAGES(SYNC_STAGES)) u_en_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d_i(en_async_i), .q_o(en_s)
    );
    tcap_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(tmr_clk), .rst_n(tmr_rst_n), .d_i(req_tgl_async_i), .q_o(req_s)
    );

    assign req_edge = req_s ^ state_q.req_prev;

    always_comb begin
        state_d          = state_q;
        state_d.req_prev = req_s;
        if (en_s) state_d.cnt = state_q.cnt + CNT_W'(1);
        if (req_edge) begin
            state_d.snap    = state_q.cnt;
            state_d.ack_tgl = ~state_q.ack_tgl;
        end
    end

    always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
        if (!tmr_rst_n) state_q <= '0;
        else            state_q <= state_d;
    end

    assign cnt_o     = state_q.cnt;
    assign snap_o    = state_q.snap;
    assign ack_tgl_o = state_q.ack_tgl;

    // R2: one step per enabled timer clock
    a_r2_count_step: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        en_s |=> state_q.cnt == $past(state_q.cnt) + CNT_W'(1));
    // R2: frozen while disabled
    a_r2_count_hold: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        !en_s |=> $stable(state_q.cnt));
    // R3: rollover to zero
    a_r3_wrap: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        (en_s && (&state_q.cnt)) |=> state_q.cnt == '0);
    // R6: snapshot only moves on a request edge
    a_r6_snap_hold: assert property (@(posedge tmr_clk) disable iff (!tmr_rst_n)
        !req_edge |=> $stable(state_q.snap));
endmodule

// File: rtl/tcap_bus_regs.sv
`timescale 1ns/1ps
module tcap_bus_regs
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic             en_o,
    output logic             sel_o,
    output logic             req_tgl_o,
    input  logic             ack_tgl_async_i,
    input  logic [CNT_W-1:0] snap_i,
    input  logic [CNT_W-1:0] live_i
);
    typedef struct packed {
        logic             en;
        logic             sel;
        logic             req_tgl;
        logic             pend;
        logic             vld;
        logic             ack_prev;
        logic [CNT_W-1:0] cap;
    } bus_st_t;

    bus_st_t state_d, state_q;
    logic    ack_s, ack_edge, ctrl_wr, unused_wbits;

    tcap_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d_i(ack_tgl_async_i), .q_o(ack_s)
    );

    assign ack_edge     = ack_s ^ state_q.ack_prev;
    assign ctrl_wr      = wr_i && (addr_i == ADDR_CTRL);
    assign unused_wbits = ^wdata_i[BUS_W-1:3];

    always_comb begin
        state_d          = state_q;
        state_d.ack_prev = ack_s;
        if (ack_edge && state_q.pend) begin
            state_d.cap  = snap_i;
            state_d.vld  = 1'b1;
            state_d.pend = 1'b0;
        end
        if (ctrl_wr) begin
            state_d.en = wdata_i[CTRL_EN_BIT];
            if (!state_q.en) state_d.sel = wdata_i[CTRL_SEL_BIT];
            if (wdata_i[CTRL_REQ_BIT] && !state_q.pend) begin
                state_d.req_tgl = ~state_q.req_tgl;
                state_d.pend    = 1'b1;
                state_d.vld     = 1'b0;
            end
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) state_q <= '0;
        else            state_q <= state_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_CTRL: begin
                rdata_o[CTRL_EN_BIT]  = state_q.en;
                rdata_o[CTRL_SEL_BIT] = state_q.sel;
            end
            ADDR_CAPT: rdata_o = BUS_W'(state_q.cap);
            ADDR_STAT: begin
                rdata_o[STAT_VLD_BIT]  = state_q.vld;
                rdata_o[STAT_PEND_BIT] = state_q.pend;
            end
            default:   rdata_o = BUS_W'(live_i);
        endcase
    end

    assign en_o      = state_q.en;
    assign sel_o     = state_q.sel;
    assign req_tgl_o = state_q.req_tgl;

    // R4: a fresh request clears valid and marks pending
    a_r4_req_clears_valid: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (ctrl_wr && wdata_i[CTRL_REQ_BIT] && !state_q.pend) |=> (!state_q.vld && state_q.pend));
    // R4: valid and pending never both set
    a_r4_exclusive: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !(state_q.vld && state_q.pend));
    // R5: no new toggle while a capture is outstanding
    a_r5_ignore_pending: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        state_q.pend |=> $stable(state_q.req_tgl));
    // R6: capture register moves only on completion
    a_r6_cap_hold: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        !(ack_edge && state_q.pend) |=> $stable(state_q.cap));
    // R10: select frozen while running
    a_r10_sel_locked: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        state_q.en |=> $stable(state_q.sel));
endmodule

// File: rtl/tcap_top.sv
`timescale 1ns/1ps
module tcap_top #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        fast_clk,
    input  logic        slow_clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic             bus_rst_n, tmr_rst_n, tmr_clk;
    logic             en, sel, req_tgl, ack_tgl;
    logic [CNT_W-1:0] cnt, snap;

    assign tmr_clk = sel ? slow_clk : fast_clk;

    tcap_rst_sync #(.STAGES(SYNC_STAGES)) u_bus_rst (
        .clk(bus_clk), .rst_n(rst_n), .rst_n_o(bus_rst_n)
    );
    tcap_rst_sync #(.STAGES(SYNC_STAGES)) u_tmr_rst (
        .clk(tmr_clk), .rst_n(rst_n), .rst_n_o(tmr_rst_n)
    );

    tcap_tmr_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .en_async_i(en), .req_tgl_async_i(req_tgl),
        .cnt_o(cnt), .snap_o(snap), .ack_tgl_o(ack_tgl)
    );

    tcap_bus_regs #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_regs (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata), .rdata_o(reg_rdata),
        .en_o(en), .sel_o(sel), .req_tgl_o(req_tgl),
        .ack_tgl_async_i(ack_tgl), .snap_i(snap), .live_i(cnt)
    );
endmodule

// File: tb/tcap_top_bench.sv
`timescale 1ns/1ps
module tcap_top_bench;
    logic bus_clk = 0, fast_clk = 0, slow_clk = 0, rst_n = 0;
    logic        wr = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        wr8 = 0;
    logic [1:0]  addr8 = 0;
    logic [31:0] wdata8 = 0, rdata8;
    int n_checks = 0, n_fail = 0;

    always #5   bus_clk  = ~bus_clk;
    always #15  fast_clk = ~fast_clk;
    always #150 slow_clk = ~slow_clk;

    tcap_top u_tcap_top (
        .bus_clk(bus_clk), .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
    );
    tcap_top #(.CNT_W(8)) u_tcap_top_w8 (
        .bus_clk(bus_clk), .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .reg_wr(wr8), .reg_addr(addr8), .reg_wdata(wdata8), .reg_rdata(rdata8)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk); wr = 1; addr = a; wdata = d;
        @(negedge bus_clk); wr = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk); addr = a; #1; d = rdata;
    endtask

    task automatic live_rd(output logic [31:0] d);
        logic [31:0] x, y;
        bus_rd(2'd3, x); bus_rd(2'd3, y);
        while (x != y) begin x = y; bus_rd(2'd3, y); end
        d = y;
    endtask

    task automatic capture(input logic [31:0] ctrl, output int lat, output logic [31:0] val);
        logic [31:0] s;
        bus_wr(2'd0, ctrl | 32'h4);
        lat = 0;
        s = 0;
        while (!s[0] && lat < 2000) begin bus_rd(2'd2, s); lat++; end
        bus_rd(2'd1, val);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[1:0], v);
            check(v == 0, "R1 reset register", v, 0);
        end
    endtask

    task automatic t_fast_run;
        logic [31:0] a, b, c; int lat;
        bus_wr(2'd0, 32'h1);
        repeat (10) @(negedge bus_clk);
        live_rd(a);
        repeat (300) @(negedge bus_clk);
        live_rd(b);
        check((b - a) >= 95 && (b - a) <= 106, "R2 fast rate", b - a, 100);
        live_rd(a);
        capture(32'h1, lat, c);
        live_rd(b);
        check(a <= c && c <= b, "R7 window low", c, a);
        check(lat <= 20, "R8 fast latency", lat, 20);
    endtask

    task automatic t_clear_and_hold;
        logic [31:0] old, s, v, v2; int lat;
        bus_rd(2'd1, old);
        bus_wr(2'd0, 32'h5);
        bus_rd(2'd2, s);
        check(s[1:0] == 2'b10, "R4 request clears valid", s, 2);
        bus_rd(2'd1, v);
        check(v == old, "R6 hold while pending", v, old);
        lat = 0; s = 0;
        while (!s[0] && lat < 2000) begin bus_rd(2'd2, s); lat++; end
        check(s[1:0] == 2'b01, "R4 completion flags", s, 1);
        bus_rd(2'd1, v);
        repeat (50) @(negedge bus_clk);
        bus_rd(2'd1, v2);
        check(v == v2, "R6 hold after completion", v2, v);
    endtask

    task automatic t_ignore_pending;
        logic [31:0] s; int lat;
        bus_wr(2'd0, 32'h5);
        bus_wr(2'd0, 32'h5);
        lat = 0; s = 0;
        while (!s[0] && lat < 2000) begin bus_rd(2'd2, s); lat++; end
        repeat (60) @(negedge bus_clk);
        bus_rd(2'd2, s);
        check(s[1:0] == 2'b01, "R5 second request ignored", s, 1);
    endtask

    task automatic t_frozen;
        logic [31:0] a, b, c; int lat;
        bus_wr(2'd0, 32'h0);
        repeat (30) @(negedge bus_clk);
        live_rd(a);
        capture(32'h0, lat, c);
        check(c == a, "R7 stopped capture exact", c, a);
        repeat (100) @(negedge bus_clk);
        live_rd(b);
        check(b == a, "R2 hold when disabled", b, a);
    endtask

    task automatic t_select;
        logic [31:0] v, a, b, c; int lat;
        bus_wr(2'd0, 32'h1);
        bus_wr(2'd0, 32'h3);
        bus_rd(2'd0, v);
        check(v == 32'h1, "R10 select locked while enabled", v, 1);
        bus_wr(2'd0, 32'h0);
        repeat (20) @(negedge bus_clk);
        bus_wr(2'd0, 32'h2);
        bus_rd(2'd0, v);
        check(v == 32'h2, "R9 select written while stopped", v, 2);
        bus_wr(2'd0, 32'h3);
        repeat (100) @(negedge bus_clk);
        live_rd(a);
        repeat (300) @(negedge bus_clk);
        live_rd(b);
        check((b - a) >= 8 && (b - a) <= 12, "R9 slow rate", b - a, 10);
        live_rd(a);
        capture(32'h3, lat, c);
        live_rd(b);
        check(lat > 40 && lat < 200, "R9 slow latency", lat, 60);
        check(a <= c && c <= b, "R7 slow window", c, a);
    endtask

    task automatic t_wrap;
        logic [31:0] prev, v; int drops;
        bit upper_ok;
        drops = 0; upper_ok = 1;
        @(negedge bus_clk); wr8 = 1; addr8 = 2'd0; wdata8 = 32'h1;
        @(negedge bus_clk); wr8 = 0; addr8 = 2'd3;
        repeat (5) @(negedge bus_clk);
        #1 prev = rdata8;
        for (int i = 0; i < 200; i++) begin
            repeat (20) @(negedge bus_clk);
            #1 v = rdata8;
            if (v[31:8] != 0) upper_ok = 0;
            if (v < prev) drops++;
            prev = v;
        end
        check(upper_ok, "R3 count stays in width", prev, 0);
        check(drops >= 3, "R3 rollover seen", drops, 4);
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #47 rst_n = 1;
        repeat (20) @(negedge bus_clk);
        t_reset();
        t_fast_run();
        t_clear_and_hold();
        t_ignore_pending();
        t_frozen();
        t_select();
        t_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule